// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host processor reach the registers of Ethernet PHYs over the two-wire management interface. The host writes word-wide registers to set up an access: a 16-bit address payload, a 16-bit write payload, and a command word. The command word selects the clause, the frame operation, the PHY port address and the register or device address. Setting the start bit in the command word launches a single frame. The block produces the management clock (MDC) with a parameterised divider. It shifts the frame out on a tri-stated data line and releases that line for read responses. It then stores the received 16 bits and a read-failure flag.

Software waits until the start bit reads back as zero before it launches the next access. Any sequence of several frames, such as a Clause 45 address frame followed by a read, is issued one command at a time by software.

Top module: `mdio_regif_master`

## Requirements
- R1: Registers are decoded on byte offsets 0x00 (command), 0x04 (address payload, low 16 bits kept), 0x08 (write payload, low 16 bits kept), 0x0C (read data, low 16 bits) and 0x10 (status, bit 0). Command fields are: device/register address in bits 4:0, port address in bits 9:5, op code in bits 11:10, clause select in bits 13:12, start in bit 14. Writing the command word with bit 14 clear stores the fields, which read back unchanged, and sends no frame.
- R2: A Clause 22 frame has 32 preamble ones, start code 01, the 2-bit op, 5-bit port, 5-bit register, turnaround 10 and 16 data bits, all sent MSB first. A write frame (op bit 1 clear) carries the write payload.
- R3: A Clause 45 frame uses start code 00. Op 0 carries the address payload register. Op 1 carries the write payload.
- R4: A frame whose op bit 1 is set is a read. The output enable drops from the first turnaround bit onward, and the 16 bits received after the turnaround appear in the read-data register, MSB first.
- R5: Bit 14 of the command register reads 1 from the cycle after launch until the frame ends, then reads 0. Each frame has exactly 64 MDC rising edges.
- R6: A command write while a frame is in progress is ignored. No extra frame is sent and the stored command fields do not change.
- R7: After a read, status bit 0 holds the level sampled on the second turnaround bit: 1 if the PHY failed to drive it low, 0 if it did. Write frames leave the status unchanged.
- R8: MDC idles low, and while running each half period lasts DIV_HALF clock cycles. The data output changes only on MDC falling edges or at launch. After a frame, MDC is low and the line is released.
- R9: After reset, MDC is low, the output enable is low, and the command, read-data and status registers read 0.
- R10: A clause-select value of 1 gives a Clause 22 frame. Any other value gives a Clause 45 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with DIV_HALF set to 2. This keeps a frame near 260 clock cycles, so it can sweep all 32 port addresses, every Clause 45 op code, a non-standard clause code and both turnaround outcomes. A bench PHY model records every bit on MDC rising edges and supplies read responses. This makes the full 64-bit frame and its output-enable pattern comparable against a value the bench builds arithmetically. The short divider also makes the half-period length and the ignored mid-frame command directly measurable.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_LAST    = 47;
    localparam int DATA_FIRST = 48;
    localparam int START_BIT  = 14;
    localparam int REG_AW     = 5;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [1:0] clause;
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dev;
    } mdio_cmd_t;

    typedef enum logic [2:0] {
        SEL_CMD = 3'd0,
        SEL_ADR = 3'd1,
        SEL_WDT = 3'd2,
        SEL_RDT = 3'd3,
        SEL_STS = 3'd4
    } reg_sel_e;

    function automatic logic is_c22(input logic [1:0] clause);
        return clause == 2'd1;
    endfunction

    function automatic logic op_is_read(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_cmd_t  c,
        input logic [15:0] addr_word,
        input logic [15:0] wr_word
    );
        logic [1:0]  st;
        logic [1:0]  ta;
        logic [15:0] pl;
        st = is_c22(c.clause) ? 2'b01 : 2'b00;
        ta = op_is_read(c.op) ? 2'b11 : 2'b10;
        if (op_is_read(c.op))
            pl = 16'h0000;
        else if (!is_c22(c.clause) && c.op == 2'd0)
            pl = addr_word;
        else
            pl = wr_word;
        return {32'hFFFF_FFFF, st, c.op, c.port, c.dev, ta, pl};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick      = run && (cnt == LAST);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] addr_word,
    input  logic [15:0] wr_word,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        rd_frame,
    output logic [15:0] rd_word,
    output logic        ta_fail
);
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] frame_w;
    logic [CNT_W-1:0]      bitcnt;
    logic                  is_rd;

    assign frame_w  = build_frame(cmd, addr_word, wr_word);
    assign done     = busy && fall_tick && (bitcnt == CNT_W'(FRAME_BITS));
    assign rd_frame = is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            is_rd   <= 1'b0;
            shreg   <= '0;
            bitcnt  <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            rd_word <= '0;
            ta_fail <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                is_rd   <= op_is_read(cmd.op);
                shreg   <= frame_w;
                mdio_o  <= frame_w[FRAME_BITS-1];
                mdio_oe <= 1'b1;
                bitcnt  <= '0;
                rd_word <= '0;
                ta_fail <= 1'b0;
            end
        end else begin
            if (rise_tick) begin
                bitcnt <= bitcnt + 1'b1;
                if (is_rd && bitcnt == CNT_W'(TA_LAST))
                    ta_fail <= mdio_i;
                if (is_rd && bitcnt >= CNT_W'(DATA_FIRST))
                    rd_word <= {rd_word[14:0], mdio_i};
            end
            if (fall_tick) begin
                if (bitcnt == CNT_W'(FRAME_BITS)) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                end else begin
                    shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                    mdio_o <= shreg[FRAME_BITS-2];
                    if (is_rd && bitcnt == CNT_W'(TA_FIRST))
                        mdio_oe <= 1'b0;
                end
            end
        end
    end

    assert_bit_bound_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> bitcnt <= CNT_W'(FRAME_BITS));

    assert_read_released_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && bitcnt > CNT_W'(TA_LAST)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              rd_frame,
    input  logic [15:0]       rd_word,
    input  logic              ta_fail,
    output logic              start,
    output mdio_cmd_t         launch_cmd,
    output logic [15:0]       addr_word,
    output logic [15:0]       wr_word
);
    reg_sel_e    sel;
    mdio_cmd_t   cmd_q;
    logic [15:0] addr_q;
    logic [15:0] wr_q;
    logic [15:0] rd_q;
    logic        fail_q;

    assign sel        = reg_sel_e'(addr[4:2]);
    assign start      = we && (sel == SEL_CMD) && wdata[START_BIT] && !busy;
    assign launch_cmd = mdio_cmd_t'(wdata[13:0]);
    assign addr_word  = addr_q;
    assign wr_word    = wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            fail_q <= 1'b0;
        end else begin
            if (we) begin
                case (sel)
                    SEL_CMD: if (!busy) cmd_q <= mdio_cmd_t'(wdata[13:0]);
                    SEL_ADR: addr_q <= wdata[15:0];
                    SEL_WDT: wr_q   <= wdata[15:0];
                    default: ;
                endcase
            end
            if (done && rd_frame) begin
                rd_q   <= rd_word;
                fail_q <= ta_fail;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_CMD: rdata = {17'd0, busy, cmd_q};
            SEL_ADR: rdata = {16'd0, addr_q};
            SEL_WDT: rdata = {16'd0, wr_q};
            SEL_RDT: rdata = {16'd0, rd_q};
            SEL_STS: rdata = {31'd0, fail_q};
            default: rdata = 32'd0;
        endcase
    end

    assert_cmd_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    assert_status_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(fail_q) |-> $past(done && rd_frame));

endmodule

// File: rtl/mdio_regif_master.sv
module mdio_regif_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        busy;
    logic        start;
    logic        done;
    logic        rd_frame;
    logic        ta_fail;
    logic        rise_tick;
    logic        fall_tick;
    logic [15:0] rd_word;
    logic [15:0] addr_word;
    logic [15:0] wr_word;
    mdio_cmd_t   launch_cmd;

    mdio_csr u_csr (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy       (busy),
        .done       (done),
        .rd_frame   (rd_frame),
        .rd_word    (rd_word),
        .ta_fail    (ta_fail),
        .start      (start),
        .launch_cmd (launch_cmd),
        .addr_word  (addr_word),
        .wr_word    (wr_word)
    );

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (launch_cmd),
        .addr_word (addr_word),
        .wr_word   (wr_word),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_frame  (rd_frame),
        .rd_word   (rd_word),
        .ta_fail   (ta_fail)
    );

    assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    assert_data_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> ($fell(mdc) || $rose(busy)));

    assert_released_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !mdio_oe);

endmodule

// File: tb/mdio_regif_master_bench.sv
module mdio_regif_master_bench;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [63:0] cap_o;
    logic [63:0] cap_oe;
    logic [63:0] resp = '1;
    int          cap_n = 0;
    int          run_hi = 0;
    int          run_lo = 0;
    int          last_hi = 0;
    int          last_lo = 0;
    logic        sts_model = 1'b0;

    always #4 clk = ~clk;

    mdio_regif_master #(.DIV_HALF(DIV)) u_mdio_regif_master (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: records each bit on MDC rise, presents the next response bit
    always @(posedge mdc) begin
        cap_o[63 - (cap_n % 64)]  <= mdio_o;
        cap_oe[63 - (cap_n % 64)] <= mdio_oe;
        mdio_i <= resp[63 - ((cap_n + 1) % 64)];
        cap_n  <= cap_n + 1;
    end

    always @(negedge clk) begin
        if (mdc) begin
            run_hi <= run_hi + 1;
            if (run_lo > 0) begin last_lo <= run_lo; run_lo <= 0; end
        end else begin
            if (run_hi > 0) begin last_hi <= run_hi; run_hi <= 0; end
            run_lo <= run_lo + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmdw(input logic [1:0] cl, input logic [1:0] op,
                                         input logic [4:0] port, input logic [4:0] dev, input bit go);
        return {17'd0, go, cl, op, port, dev};
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin rd(5'h00, v); n++; end while (v[14] && n < 5000);
    endtask

    task automatic do_frame(input logic [1:0] cl, input logic [1:0] op, input logic [4:0] port,
                            input logic [4:0] dev, input logic [15:0] aw, input logic [15:0] ww,
                            input bit ta_bit, input logic [15:0] dat, input string req);
        logic [31:0] v;
        logic [63:0] exp, mask;
        logic [15:0] pl;
        bit c22, isrd;
        int base;
        c22  = (cl == 2'd1);
        isrd = op[1];
        resp = {32'hFFFF_FFFF, 14'h3FFF, 1'b1, ta_bit, dat};
        wr(5'h04, {16'hDEAD, aw});
        wr(5'h08, {16'hBEEF, ww});
        base = cap_n;
        wr(5'h00, cmdw(cl, op, port, dev, 1'b1));
        rd(5'h00, v);
        check(v[14] == 1'b1, "R5 busy bit", {63'd0, v[14]}, 64'd1);
        wait_idle();
        if (isrd) pl = 16'h0;
        else if (!c22 && op == 2'd0) pl = aw;
        else pl = ww;
        exp  = {32'hFFFF_FFFF, (c22 ? 2'b01 : 2'b00), op, port, dev, 2'b10, pl};
        mask = isrd ? {{46{1'b1}}, {18{1'b0}}} : '1;
        check(cap_n - base == 64, "R5 edge count", 64'(cap_n - base), 64'd64);
        check(((cap_o ^ exp) & mask) == 0, req, cap_o & mask, exp & mask);
        check(cap_oe == mask, isrd ? "R4 oe pattern" : req, cap_oe, mask);
        check(!mdc && !mdio_oe, "R8 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
        if (isrd) begin
            sts_model = ta_bit;
            if (!ta_bit) begin
                rd(5'h0C, v);
                check(v == {16'd0, dat}, "R4 read data", 64'(v), 64'(dat));
            end
        end
        rd(5'h10, v);
        check(v == {31'd0, sts_model}, "R7 status", 64'(v), 64'(sts_model));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check(!mdc && !mdio_oe, "R9 pins", {62'd0, mdc, mdio_oe}, 64'd0);
        rd(5'h00, v); check(v == 0, "R9 command", 64'(v), 64'd0);
        rd(5'h0C, v); check(v == 0, "R9 read data", 64'(v), 64'd0);
        rd(5'h10, v); check(v == 0, "R9 status", 64'(v), 64'd0);

        // R1 store without start
        base = cap_n;
        wr(5'h00, cmdw(2'd2, 2'd3, 5'd21, 5'd10, 1'b0));
        repeat (100) @(negedge clk);
        rd(5'h00, v);
        check(v == cmdw(2'd2, 2'd3, 5'd21, 5'd10, 1'b0), "R1 readback", 64'(v), 64'(cmdw(2'd2, 2'd3, 5'd21, 5'd10, 1'b0)));
        check(cap_n == base, "R1 no frame", 64'(cap_n - base), 64'd0);
        wr(5'h04, 32'hFFFF_1357); rd(5'h04, v);
        check(v == 32'h0000_1357, "R1 address low half", 64'(v), 64'h1357);

        // R2 Clause 22 writes over all port addresses
        for (int p = 0; p < 32; p++)
            do_frame(2'd1, 2'd1, 5'(p), 5'(31 - p), 16'h0, 16'(p * 16'h0421 + 16'h1000), 1'b0, 16'h0, "R2 c22 write frame");

        // R4 / R7 Clause 22 reads
        do_frame(2'd1, 2'd2, 5'd5, 5'd2, 16'h0, 16'h0, 1'b0, 16'hA5C3, "R4 c22 read frame");
        do_frame(2'd1, 2'd2, 5'd6, 5'd3, 16'h0, 16'h0, 1'b1, 16'h1234, "R7 c22 read ta fail");
        do_frame(2'd1, 2'd1, 5'd6, 5'd3, 16'h0, 16'h4242, 1'b0, 16'h0, "R7 write keeps status");

        // R3 Clause 45 op codes
        do_frame(2'd0, 2'd0, 5'd9, 5'd3, 16'h1234, 16'h5555, 1'b0, 16'h0, "R3 c45 address frame");
        do_frame(2'd0, 2'd1, 5'd9, 5'd3, 16'h1234, 16'hBEEF, 1'b0, 16'h0, "R3 c45 write frame");
        do_frame(2'd0, 2'd2, 5'd9, 5'd3, 16'h0, 16'h0, 1'b0, 16'h0F0F, "R4 c45 read-inc frame");
        do_frame(2'd0, 2'd3, 5'd17, 5'd30, 16'h0, 16'h0, 1'b0, 16'h7E81, "R4 c45 read frame");

        // R10 other clause code behaves as Clause 45
        do_frame(2'd2, 2'd1, 5'd12, 5'd7, 16'h0, 16'hC0DE, 1'b0, 16'h0, "R10 clause 2 frame");
        do_frame(2'd3, 2'd0, 5'd1, 5'd1, 16'hABCD, 16'h0, 1'b0, 16'h0, "R10 clause 3 frame");

        // R8 MDC half periods
        check(last_hi == DIV, "R8 high time", 64'(last_hi), 64'(DIV));
        check(last_lo == DIV, "R8 low time", 64'(last_lo), 64'(DIV));

        // R6 command while busy
        resp = '1;
        wr(5'h08, 32'h0000_1111);
        base = cap_n;
        wr(5'h00, cmdw(2'd1, 2'd1, 5'd3, 5'd4, 1'b1));
        repeat (20) @(negedge clk);
        wr(5'h00, cmdw(2'd0, 2'd3, 5'd7, 5'd9, 1'b1));
        wait_idle();
        repeat (300) @(negedge clk);
        check(cap_n - base == 64, "R6 single frame", 64'(cap_n - base), 64'd64);
        rd(5'h00, v);
        check(v == cmdw(2'd1, 2'd1, 5'd3, 5'd4, 1'b0), "R6 fields kept", 64'(v), 64'(cmdw(2'd1, 2'd1, 5'd3, 5'd4, 1'b0)));
        check(cap_o == {32'hFFFF_FFFF, 2'b01, 2'd1, 5'd3, 5'd4, 2'b10, 16'h1111}, "R6 first frame sent",
              cap_o, {32'hFFFF_FFFF, 2'b01, 2'd1, 5'd3, 5'd4, 2'b10, 16'h1111});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule